// File: doc/BRIEF.md
# AUX Transaction Retry Sequencer

This controller drives one complete transaction on an auxiliary display channel. It works through the channel's register front-end. A start pulse brings in the number of bytes to send and the size of the receive buffer. The sequencer first makes sure the channel is idle and that both counts are in range. It then issues attempts, each tagged with a bit-clock divider value taken from a short table. Once the transaction has settled, it reports a result code and a receive length.

Every attempt is followed by a one-cycle clear pulse, which tells the front-end to write back its done and error flags. The decision to retry depends on which flag was raised:

- A timeout starts the next attempt at once.
- A receive error first waits out a back-off period.
- A clean completion ends the run.

Each divider gets a fixed number of attempts before the next table entry is used. A zero entry, or the end of the table, stops the walk. All waits come from a microsecond tick that is derived from the clock-frequency parameter.

Top module: `aux_xact_sequencer`

## Requirements
- R1: After start, the channel-busy input is sampled up to 3 times. Samples are spaced by POLL_GAP_US microseconds (1000 by default). If all three samples show busy, the run ends with result BUSY and no attempt is launched.
- R2: If the send count or the receive capacity is above MAX_BYTES (20), the run ends with result TOOBIG and no attempt is launched.
- R3: Each divider value is given at most MAX_TRIES attempts (5). During an attempt pulse, launch_div_o carries that table entry. Entry k occupies bits [k*DIV_W +: DIV_W] of div_table_i, and entries are used in ascending k.
- R4: Every attempt produces exactly one clear_o pulse. The pulse comes after the channel reports it is no longer busy.
- R5: When an attempt ends with the timeout flag set, the next attempt starts without any wait, even if the receive-error flag is also set.
- R6: When an attempt ends with the receive-error flag set and the timeout flag clear, at least BACKOFF_US microseconds (400) pass before the next attempt or the end of the run.
- R7: The divider walk stops at the first zero entry or after NDIV entries. If entry 0 is zero, no attempt is made and the result is BUSY.
- R8: The final status is judged in this order. Done flag clear gives BUSY (code 1). Receive error gives IOERR (code 3). Timeout gives TIMEOUT (code 2). Otherwise the result is OK (code 0). TOOBIG is code 4.
- R9: A completed attempt that reports a received size of 0 or above MAX_BYTES gives result BUSY.
- R10: When the result is OK, rx_len_o equals the smaller of the reported size and the receive capacity. For any other result, rx_len_o is 0.
- R11: busy_o is high from the cycle after start until the run ends. done_o pulses for exactly one cycle while result_o and rx_len_o are valid.
- R12: A start pulse that arrives while busy_o is high is ignored. It does not change the running transaction and does not add a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for one transaction |
| tx_cnt_i | input | 5 | Bytes to send |
| rx_cap_i | input | 5 | Receive buffer capacity in bytes |
| div_table_i | input | NDIV*DIV_W | Divider values, entry k at bits [k*DIV_W +: DIV_W] |
| chan_busy_i | input | 1 | Channel send-busy flag |
| chan_done_i | input | 1 | Attempt done flag |
| chan_tmo_i | input | 1 | Attempt timeout flag |
| chan_rxe_i | input | 1 | Attempt receive-error flag |
| chan_size_i | input | 5 | Received message size |
| launch_o | output | 1 | Start one attempt |
| launch_div_o | output | DIV_W | Divider for this attempt |
| launch_len_o | output | 5 | Send count for this attempt |
| clear_o | output | 1 | Write back done and error flags to clear them |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-run strobe |
| result_o | output | 3 | Result code |
| rx_len_o | output | 5 | Clamped receive length |

## Verification
A wrong retry counter or divider index shows up at the ports as a changed number of launch pulses before done_o, or as a wrong divider on the sixth launch. Either is visible as soon as the run ends. A wrong decision branch or a bad back-off timer shows up as wrong elapsed time from start to done_o. A receive-error case finishing in a few dozen cycles, or a timeout case taking hundreds, is caught at the end of that transaction. A wrong judge priority or a missing clamp shows up in result_o and rx_len_o on the done_o cycle itself.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;
  parameter int unsigned STAT_SIZE_W = 5;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_BUSY    = 3'd1,
    RES_TIMEOUT = 3'd2,
    RES_IOERR   = 3'd3,
    RES_TOOBIG  = 3'd4
  } aux_result_e;

  typedef struct packed {
    logic                   done;
    logic                   tmo;
    logic                   rxe;
    logic [STAT_SIZE_W-1:0] size;
  } aux_stat_t;
endpackage

// File: rtl/aux_us_delay.sv
module aux_us_delay #(
  parameter int unsigned CLK_MHZ = 50,
  parameter int unsigned US_W    = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [US_W-1:0] load_us,
  output logic            expired
);
  localparam int unsigned PRE_W = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [US_W-1:0]  rem_q, rem_d;
  logic             tick;

  assign tick = (pre_q == PRE_W'(CLK_MHZ - 1));

  always_comb begin
    if (load) begin
      pre_d = '0;
      rem_d = load_us;
    end else begin
      pre_d = tick ? '0 : pre_q + 1'b1;
      rem_d = (tick && rem_q != '0) ? rem_q - 1'b1 : rem_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      rem_q <= '0;
    end else begin
      pre_q <= pre_d;
      rem_q <= rem_d;
    end
  end

  assign expired = (rem_q == '0);

  AST_DELAY_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && rem_q != '0) |=> (rem_q <= $past(rem_q))); // R6
endmodule

// File: rtl/aux_div_select.sv
module aux_div_select #(
  parameter int unsigned NDIV  = 4,
  parameter int unsigned DIV_W = 8,
  parameter int unsigned IDX_W = $clog2(NDIV + 1)
) (
  input  logic [NDIV*DIV_W-1:0] table_i,
  input  logic [IDX_W-1:0]      idx_i,
  output logic [DIV_W-1:0]      div_o,
  output logic                  list_end_o
);
  logic [DIV_W-1:0] ent [NDIV];

  for (genvar g = 0; g < NDIV; g++) begin : g_ent
    assign ent[g] = table_i[g*DIV_W +: DIV_W];
  end

  always_comb begin
    div_o = '0;
    for (int k = 0; k < NDIV; k++) begin
      if (idx_i == IDX_W'(k)) div_o = ent[k];
    end
  end

  assign list_end_o = (div_o == '0);
endmodule

// File: rtl/aux_status_judge.sv
module aux_status_judge
  import aux_seq_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 20,
  parameter int unsigned CNT_W     = STAT_SIZE_W
) (
  input  aux_stat_t         stat_i,
  input  logic [CNT_W-1:0]  cap_i,
  output aux_result_e       res_o,
  output logic [CNT_W-1:0]  len_o
);
  logic size_bad;
  assign size_bad = (stat_i.size == '0) || (stat_i.size > CNT_W'(MAX_BYTES));

  always_comb begin
    len_o = '0;
    if (!stat_i.done)      res_o = RES_BUSY;
    else if (stat_i.rxe)   res_o = RES_IOERR;
    else if (stat_i.tmo)   res_o = RES_TIMEOUT;
    else if (size_bad)     res_o = RES_BUSY;
    else begin
      res_o = RES_OK;
      len_o = (stat_i.size > cap_i) ? cap_i : stat_i.size;
    end
  end
endmodule

// File: rtl/aux_xact_sequencer.sv
module aux_xact_sequencer
  import aux_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 50,
  parameter int unsigned NDIV        = 4,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned MAX_BYTES   = 20,
  parameter int unsigned MAX_TRIES   = 5,
  parameter int unsigned POLL_READS  = 3,
  parameter int unsigned POLL_GAP_US = 1000,
  parameter int unsigned BACKOFF_US  = 400
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [4:0]            tx_cnt_i,
  input  logic [4:0]            rx_cap_i,
  input  logic [NDIV*DIV_W-1:0] div_table_i,
  input  logic                  chan_busy_i,
  input  logic                  chan_done_i,
  input  logic                  chan_tmo_i,
  input  logic                  chan_rxe_i,
  input  logic [4:0]            chan_size_i,
  output logic                  launch_o,
  output logic [DIV_W-1:0]      launch_div_o,
  output logic [4:0]            launch_len_o,
  output logic                  clear_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [2:0]            result_o,
  output logic [4:0]            rx_len_o
);
  localparam int unsigned CNT_W   = STAT_SIZE_W;
  localparam int unsigned IDX_W   = $clog2(NDIV + 1);
  localparam int unsigned TRY_W   = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
  localparam int unsigned POLL_W  = (POLL_READS > 1) ? $clog2(POLL_READS) : 1;
  localparam int unsigned TMR_MAX = (POLL_GAP_US > BACKOFF_US) ? POLL_GAP_US : BACKOFF_US;
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_POLL, S_GAP, S_CHECK, S_SELECT,
    S_LAUNCH, S_SETTLE, S_WAIT, S_CLEAR, S_BACKOFF
  } seq_state_e;

  seq_state_e        state_q, state_d;
  logic [POLL_W-1:0] poll_q, poll_d;
  logic [TRY_W-1:0]  try_q, try_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  tx_q, tx_d, cap_q, cap_d;
  aux_stat_t         stat_q, stat_d;
  aux_result_e       res_q, res_d;
  logic [CNT_W-1:0]  len_q, len_d;
  logic              done_q, done_d;

  logic              tmr_load, tmr_expired;
  logic [TMR_W-1:0]  tmr_us;
  logic [DIV_W-1:0]  cur_div;
  logic              list_end;
  aux_result_e       judge_res;
  logic [CNT_W-1:0]  judge_len;

  aux_us_delay #(.CLK_MHZ(CLK_MHZ), .US_W(TMR_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_us(tmr_us), .expired(tmr_expired)
  );

  aux_div_select #(.NDIV(NDIV), .DIV_W(DIV_W), .IDX_W(IDX_W)) u_divsel (
    .table_i(div_table_i), .idx_i(idx_q), .div_o(cur_div), .list_end_o(list_end)
  );

  aux_status_judge #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_judge (
    .stat_i(stat_q), .cap_i(cap_q), .res_o(judge_res), .len_o(judge_len)
  );

  always_comb begin
    state_d  = state_q;
    poll_d   = poll_q;
    try_d    = try_q;
    idx_d    = idx_q;
    tx_d     = tx_q;
    cap_d    = cap_q;
    stat_d   = stat_q;
    res_d    = res_q;
    len_d    = len_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_us   = '0;
    launch_o = 1'b0;
    clear_o  = 1'b0;

    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          tx_d    = tx_cnt_i;
          cap_d   = rx_cap_i;
          poll_d  = '0;
          stat_d  = '0;
          state_d = S_POLL;
        end
      end
      S_POLL: begin
        if (!chan_busy_i) begin
          state_d = S_CHECK;
        end else if (poll_q == POLL_W'(POLL_READS - 1)) begin
          res_d = RES_BUSY; len_d = '0; done_d = 1'b1; state_d = S_IDLE;
        end else begin
          poll_d   = poll_q + 1'b1;
          tmr_load = 1'b1;
          tmr_us   = TMR_W'(POLL_GAP_US);
          state_d  = S_GAP;
        end
      end
      S_GAP: if (tmr_expired) state_d = S_POLL;
      S_CHECK: begin
        if (tx_q > CNT_W'(MAX_BYTES) || cap_q > CNT_W'(MAX_BYTES)) begin
          res_d = RES_TOOBIG; len_d = '0; done_d = 1'b1; state_d = S_IDLE;
        end else begin
          idx_d = '0; try_d = '0; state_d = S_SELECT;
        end
      end
      S_SELECT: begin
        if (list_end) begin
          res_d = judge_res; len_d = judge_len; done_d = 1'b1; state_d = S_IDLE;
        end else begin
          state_d = S_LAUNCH;
        end
      end
      S_LAUNCH: begin
        launch_o = 1'b1;
        state_d  = S_SETTLE;
      end
      S_SETTLE: state_d = S_WAIT;
      S_WAIT: begin
        if (!chan_busy_i) begin
          stat_d  = '{done: chan_done_i, tmo: chan_tmo_i, rxe: chan_rxe_i, size: chan_size_i};
          state_d = S_CLEAR;
        end
      end
      S_CLEAR: begin
        clear_o = 1'b1;
        if (stat_q.tmo) begin
          state_d = S_SELECT;
          if (try_q == TRY_W'(MAX_TRIES - 1)) begin try_d = '0; idx_d = idx_q + 1'b1; end
          else try_d = try_q + 1'b1;
        end else if (stat_q.rxe) begin
          tmr_load = 1'b1;
          tmr_us   = TMR_W'(BACKOFF_US);
          state_d  = S_BACKOFF;
        end else if (stat_q.done) begin
          res_d = judge_res; len_d = judge_len; done_d = 1'b1; state_d = S_IDLE;
        end else begin
          state_d = S_SELECT;
          if (try_q == TRY_W'(MAX_TRIES - 1)) begin try_d = '0; idx_d = idx_q + 1'b1; end
          else try_d = try_q + 1'b1;
        end
      end
      S_BACKOFF: begin
        if (tmr_expired) begin
          state_d = S_SELECT;
          if (try_q == TRY_W'(MAX_TRIES - 1)) begin try_d = '0; idx_d = idx_q + 1'b1; end
          else try_d = try_q + 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      poll_q  <= '0;
      try_q   <= '0;
      idx_q   <= '0;
      tx_q    <= '0;
      cap_q   <= '0;
      stat_q  <= '0;
      res_q   <= RES_OK;
      len_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      poll_q  <= poll_d;
      try_q   <= try_d;
      idx_q   <= idx_d;
      tx_q    <= tx_d;
      cap_q   <= cap_d;
      stat_q  <= stat_d;
      res_q   <= res_d;
      len_q   <= len_d;
      done_q  <= done_d;
    end
  end

  assign launch_div_o = cur_div;
  assign launch_len_o = tx_q;
  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = done_q;
  assign result_o     = res_q;
  assign rx_len_o     = len_q;

  AST_LAUNCH_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    launch_o |-> (tx_q <= CNT_W'(MAX_BYTES) && cap_q <= CNT_W'(MAX_BYTES))); // R2
  AST_LAUNCH_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    launch_o |-> (launch_div_o != '0)); // R7
  AST_CLEAR_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clear_o |-> $past(!chan_busy_i)); // R4
  AST_BACKOFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BACKOFF && !tmr_expired) |=> (state_q == S_BACKOFF)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11
  AST_OK_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o == RES_OK) |-> (rx_len_o != '0 && rx_len_o <= cap_q)); // R10
endmodule

// File: tb/sim_aux_xact_sequencer.sv
module sim_aux_xact_sequencer;
  localparam int NDIV = 4;
  localparam int DIV_W = 8;

  logic clk, rst_n, start_i;
  logic [4:0] tx_cnt_i, rx_cap_i, chan_size_i;
  logic [NDIV*DIV_W-1:0] div_table_i;
  logic chan_busy_i, chan_done_i, chan_tmo_i, chan_rxe_i;
  logic launch_o, clear_o, busy_o, done_o;
  logic [DIV_W-1:0] launch_div_o;
  logic [4:0] launch_len_o, rx_len_o;
  logic [2:0] result_o;

  aux_xact_sequencer #(.CLK_MHZ(2), .NDIV(NDIV), .DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_cnt_i(tx_cnt_i), .rx_cap_i(rx_cap_i),
    .div_table_i(div_table_i), .chan_busy_i(chan_busy_i), .chan_done_i(chan_done_i),
    .chan_tmo_i(chan_tmo_i), .chan_rxe_i(chan_rxe_i), .chan_size_i(chan_size_i),
    .launch_o(launch_o), .launch_div_o(launch_div_o), .launch_len_o(launch_len_o),
    .clear_o(clear_o), .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .rx_len_o(rx_len_o));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // channel model: script of per-attempt flags {done,tmo,rxe,size}
  bit  s_done[8], s_tmo[8], s_rxe[8];
  int  s_size[8];
  int  s_len = 1, s_base = 0;
  logic force_busy = 1'b0;
  logic mdl_busy = 1'b0;
  int  mdl_cnt = 0, n_launch = 0, n_clear = 0;
  int  div_log[256];

  assign chan_busy_i = mdl_busy | force_busy;

  always @(posedge clk) begin
    if (launch_o) begin
      int r;
      r = n_launch - s_base;
      if (r >= s_len) r = s_len - 1;
      mdl_busy    <= 1'b1;
      mdl_cnt     <= 3;
      chan_done_i <= s_done[r];
      chan_tmo_i  <= s_tmo[r];
      chan_rxe_i  <= s_rxe[r];
      chan_size_i <= 5'(s_size[r]);
      div_log[n_launch % 256] <= int'(launch_div_o);
      n_launch <= n_launch + 1;
    end else if (mdl_busy) begin
      if (mdl_cnt == 0) mdl_busy <= 1'b0;
      else mdl_cnt <= mdl_cnt - 1;
    end
    if (clear_o) n_clear <= n_clear + 1;
  end

  typedef struct {
    int res; int len; int nl; int lo; int hi; string tag;
    int bl; int bc; int t0;
  } exp_t;
  exp_t exp_q[$];

  // monitor
  always @(negedge clk) begin
    if (done_o) begin
      if (exp_q.size() == 0) begin
        chk(0, "R12 unexpected done", 1, 0);
      end else begin
        exp_t e;
        int el;
        e = exp_q.pop_front();
        el = cyc - e.t0;
        chk(int'(result_o) == e.res, {e.tag, " result"}, int'(result_o), e.res);
        chk(int'(rx_len_o) == e.len, {e.tag, " rx_len R10"}, int'(rx_len_o), e.len);
        chk(n_launch - e.bl == e.nl, {e.tag, " launches"}, n_launch - e.bl, e.nl);
        chk(n_clear - e.bc == e.nl, {e.tag, " clears R4"}, n_clear - e.bc, e.nl);
        chk(el >= e.lo && el <= e.hi, {e.tag, " elapsed"}, el, e.lo);
      end
    end
  end

  task automatic script1(input bit d, input bit t, input bit r, input int sz);
    s_len = 1; s_done[0] = d; s_tmo[0] = t; s_rxe[0] = r; s_size[0] = sz;
  endtask

  task automatic run(input int tx, input int cap, input int res, input int len, input int nl,
                     input int lo, input int hi, input string tag, input int stray_at = -1);
    exp_t e;
    @(negedge clk);
    s_base = n_launch;
    e.res = res; e.len = len; e.nl = nl; e.lo = lo; e.hi = hi; e.tag = tag;
    e.bl = n_launch; e.bc = n_clear; e.t0 = cyc;
    exp_q.push_back(e);
    start_i = 1'b1; tx_cnt_i = 5'(tx); rx_cap_i = 5'(cap);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, {tag, " busy after start R11"}, int'(busy_o), 1);
    if (stray_at >= 0) begin
      repeat (stray_at) @(negedge clk);
      start_i = 1'b1; tx_cnt_i = 5'd25;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, {tag, " idle after done R11"}, int'(busy_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; tx_cnt_i = '0; rx_cap_i = '0;
    chan_done_i = 0; chan_tmo_i = 0; chan_rxe_i = 0; chan_size_i = '0;
    div_table_i = {8'd0, 8'd0, 8'd20, 8'd10};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 0, "reset busy R11", int'(busy_o), 0);
    chk(done_o == 0, "reset done R11", int'(done_o), 0);
    chk(launch_o == 0 && clear_o == 0, "reset launch/clear R3", int'(launch_o), 0);

    // R8/R10 plain success, size below capacity
    script1(1, 0, 0, 5);
    run(4, 16, 0, 5, 1, 5, 40, "R8 ok");
    chk(div_log[(n_launch - 1) % 256] == 10, "R3 first divider", div_log[(n_launch - 1) % 256], 10);
    // R10 clamp
    script1(1, 0, 0, 12);
    run(4, 4, 0, 4, 1, 5, 40, "R10 clamp");
    // R2 too big
    run(21, 4, 4, 0, 0, 1, 20, "R2 tx");
    run(3, 21, 4, 0, 0, 1, 20, "R2 cap");
    // R1 stuck busy
    force_busy = 1'b1;
    run(4, 4, 1, 0, 0, 3990, 4100, "R1 stuck");
    // R1 busy clears after first gap
    fork
      begin repeat (100) @(negedge clk); force_busy = 1'b0; end
    join_none
    script1(1, 0, 0, 2);
    run(4, 4, 0, 2, 1, 1995, 2100, "R1 clears");
    // R5/R3 timeouts across two dividers
    script1(1, 1, 0, 1);
    run(4, 4, 2, 0, 10, 30, 300, "R5 timeout");
    chk(div_log[(n_launch - 6) % 256] == 10, "R3 fifth try div", div_log[(n_launch - 6) % 256], 10);
    chk(div_log[(n_launch - 5) % 256] == 20, "R3 sixth try div", div_log[(n_launch - 5) % 256], 20);
    // R8 priority: timeout + rxe retried at once, final IOERR
    script1(1, 1, 1, 1);
    run(4, 4, 3, 0, 10, 30, 300, "R8 tmo+rxe");
    // R6 rx error then success, with stray start (R12)
    s_len = 2;
    s_done[0] = 1; s_tmo[0] = 0; s_rxe[0] = 1; s_size[0] = 1;
    s_done[1] = 1; s_tmo[1] = 0; s_rxe[1] = 0; s_size[1] = 3;
    run(4, 8, 0, 3, 2, 800, 900, "R6 R12 backoff", 200);
    // R6 rx error always, single divider
    div_table_i = {8'd0, 8'd9, 8'd0, 8'd7};
    script1(1, 0, 1, 1);
    run(4, 4, 3, 0, 5, 4000, 4200, "R6 ioerr");
    // R8 never done, R7 stops at zero entry
    script1(0, 0, 0, 0);
    run(4, 4, 1, 0, 5, 20, 200, "R7 R8 not done");
    // R9 illegal sizes
    script1(1, 0, 0, 0);
    run(4, 4, 1, 0, 1, 5, 40, "R9 size0");
    script1(1, 0, 0, 25);
    run(4, 4, 1, 0, 1, 5, 40, "R9 size25");
    // R7 empty table
    div_table_i = {8'd5, 8'd5, 8'd5, 8'd0};
    run(4, 4, 1, 0, 0, 1, 20, "R7 empty");
    // R7 full table walks all NDIV entries
    div_table_i = {8'd4, 8'd3, 8'd2, 8'd1};
    script1(1, 1, 0, 1);
    run(4, 4, 2, 0, 20, 60, 600, "R7 full");
    chk(div_log[(n_launch - 1) % 256] == 4, "R3 last divider", div_log[(n_launch - 1) % 256], 4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule